// File: doc/BRIEF.md
# ULPI PHY-side bus controller

This block is the PHY end of an 8-bit ULPI link bus that runs at 60 MHz. It owns the direction and throttle lines (`dir`, `nxt`) and samples the stop line and the shared data bus. While the bus belongs to the link, the block waits for a nonzero command byte. It passes transmit packet bytes out on a simple byte stream and throttles them with `nxt`. It writes register-write bytes into a small register file and returns register-read data. It takes the bus to report receive activity, to forward received bytes from a byte-stream input and to send status bytes (RX CMD). In a low-power mode it holds the bus, stops the interface clock and places line state and an interrupt on fixed data bits.

The controller is one state machine. Its states are S_IDLE (link owns the bus), S_TXC (command held, accepted with `nxt`), S_TXD (transmit bytes), S_WR (register write byte), S_WR_STP (wait for stop after a write), S_RD_TURN and S_RD_DATA (register read), S_RX_TURN and S_RX (receive), S_CMD_TURN and S_CMD (unsolicited RX CMD), S_LP_TURN and S_LP (low power), and S_BACK (turnaround back to the link).

The transitions are as follows. S_IDLE goes to S_LP_TURN, S_RX_TURN, S_CMD_TURN or S_TXC, in that priority. S_TXC goes to S_TXD, S_WR or S_RD_TURN when `nxt` accepts the command. It goes to S_IDLE on stop and to S_RX_TURN on receive. S_TXD, S_WR and S_WR_STP go to S_IDLE on stop, and S_WR goes to S_WR_STP after its byte. Every transmit-side state goes to S_RX_TURN when a receive starts. S_RD_TURN goes to S_RD_DATA, then to S_BACK. S_RX_TURN goes to S_RX, which stays until receive activity ends and then goes to S_BACK. S_CMD_TURN goes to S_CMD, then to S_BACK. S_LP_TURN goes to S_LP, which stays until low power is released and then goes to S_BACK. S_BACK goes to S_IDLE.

Top module: `ulpi_phy_port`

## Requirements
- R1: While reset is held, `dir`, `nxt` and `bus_oe` are 0 and `clk_run` is 1.
- R2: In S_IDLE, a command is captured only when three things hold: `stp` is low, the byte is nonzero, and its bits 7:6 are not 00. `nxt` stays low in the first cycle the command is shown. From the next cycle `nxt` follows `tx_ready`. A command shown while `stp` is high, or one with prefix 00, is ignored.
- R3: A transmit command has prefix 01 in bits 7:6 and the packet identifier in bits 3:0, which appears on `tx_pid`. After acceptance, each bus byte in a cycle with `nxt` high and `stp` low appears on `tx_byte` with `tx_valid`. With `tx_ready` low, `nxt` is low and no byte is taken.
- R4: `stp` high during a transmit pulses `tx_last` and returns to S_IDLE, so `nxt` is low in the next cycle.
- R5: A register-write command has prefix 10 and the address in bits 5:0. The byte after acceptance, taken with `nxt` high, is written to that register. Addresses at or above NREG are ignored.
- R6: A register-read command has prefix 11 and the address in bits 5:0. After acceptance there is one cycle with `dir` high and `bus_oe` low. Then one cycle drives the register value with `nxt` low. Then `dir` drops. Out-of-range addresses read 00h.
- R7: A receive that starts while `dir` is low raises `dir` and `nxt` together in one cycle, with `bus_oe` low in that cycle.
- R8: During a receive, a valid `rx_byte` is driven with `nxt` high. Otherwise an RX CMD is driven with `nxt` low: bits 1:0 are `line_state`, bit 4 is `rx_active`, and the other bits are 0. When `rx_active` falls, `dir` drops in the next cycle.
- R9: A change of `line_state` in S_IDLE sends one unsolicited RX CMD. This takes a turnaround cycle, one drive cycle and a turnaround back. No further RX CMD is sent while the line state stays unchanged.
- R10: A receive that starts during a transmit or register-write sequence pulses `tx_drop` and starts the receive in the next cycle. No `tx_last` follows.
- R11: With `lp_en`, the block takes the bus after one turnaround cycle. It then holds `dir` high, sets `clk_run` to 0 and drives bits 1:0 with `line_state` and bit 3 with `lp_int`; all other bits are 0. Releasing `lp_en` returns the bus with a turnaround cycle and sets `clk_run` back to 1.
- R12: In the cycle after any change of `dir`, `bus_oe` is low and the sampled bus is ignored. A command byte present in the return turnaround does not start a command.
- R13: In S_IDLE the priority is low power, then receive, then line-state change, then command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 8 | Data bus as sampled from the link |
| bus_out | output | 8 | Data driven by the PHY |
| bus_oe | output | 1 | PHY drives the data bus |
| dir | output | 1 | Bus direction, 1 = PHY owns the bus |
| nxt | output | 1 | Throttle and receive-start strobe |
| stp | input | 1 | Link stop strobe (pulled high when undriven) |
| tx_ready | input | 1 | Downstream can take a transmit byte |
| tx_pid | output | 4 | Packet identifier of the current transmit |
| tx_byte | output | 8 | Transmit packet byte |
| tx_valid | output | 1 | `tx_byte` is taken this cycle |
| tx_last | output | 1 | Transmit packet ended by stop |
| tx_drop | output | 1 | Transmit sequence aborted by a receive |
| rx_active | input | 1 | Receive activity present |
| rx_valid | input | 1 | `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte stream |
| line_state | input | 2 | Current line state |
| lp_en | input | 1 | Request for low-power mode |
| lp_int | input | 1 | Interrupt level shown in low power |
| clk_run | output | 1 | Interface clock enable, 0 in low power |

## Verification
The bench targets four corner cases. The first is the first command cycle: a design that raised `nxt` at once would let the link drop a command before it was decoded. The second is the return turnaround: a nonzero byte left on the bus would start a false command if the design sampled it. The third is a receive that arrives mid-packet: the transmit must be dropped without a `tx_last`, with `dir` and `nxt` rising together. It also covers register addresses beyond the file and aliasing into it, a stop that arrives on a floating bus, and low power winning over a simultaneous receive. A design that chose the wrong priority would show `nxt` high in place of the low-power turnaround.

// File: rtl/ulpi_phy_pkg.sv
package ulpi_phy_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_TXC, S_TXD, S_WR, S_WR_STP,
        S_RD_TURN, S_RD_DATA, S_RX_TURN, S_RX,
        S_CMD_TURN, S_CMD, S_LP_TURN, S_LP, S_BACK
    } bus_state_t;

    localparam logic [1:0] PFX_TX = 2'b01;
    localparam logic [1:0] PFX_WR = 2'b10;
    localparam logic [1:0] PFX_RD = 2'b11;

    function automatic logic [7:0] status_byte(input logic active, input logic [1:0] ls);
        return {3'b000, active, 2'b00, ls};
    endfunction

    function automatic logic [7:0] sleep_byte(input logic intr, input logic [1:0] ls);
        return {4'b0000, intr, 1'b0, ls};
    endfunction

endpackage

// File: rtl/ulpi_regfile.sv
module ulpi_regfile #(
    parameter int NREG = 8,
    parameter int AW   = 6,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++)
                if (addr == AW'(i)) regs[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (addr == AW'(i)) rd_data = regs[i];
    end
endmodule

// File: rtl/ulpi_bus_fsm.sv
module ulpi_bus_fsm
    import ulpi_phy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_in,
    input  logic       stp,
    input  logic       tx_ready,
    input  logic       rx_active,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic [1:0] line_state,
    input  logic       lp_en,
    input  logic       lp_int,
    input  logic [7:0] rd_data,
    output logic [7:0] cmd_q,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       dir,
    output logic       nxt,
    output logic       clk_run,
    output logic       tx_valid,
    output logic       tx_last,
    output logic       tx_drop,
    output logic       wr_en
);
    bus_state_t state, state_nx;
    logic [1:0] ls_last;
    logic       ls_change;
    logic       cmd_seen;

    assign ls_change = (line_state != ls_last);
    assign cmd_seen  = !stp && (bus_in != '0) && (bus_in[7:6] != 2'b00);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (lp_en)          state_nx = S_LP_TURN;
                else if (rx_active) state_nx = S_RX_TURN;
                else if (ls_change) state_nx = S_CMD_TURN;
                else if (cmd_seen)  state_nx = S_TXC;
            end
            S_TXC: begin
                if (rx_active)     state_nx = S_RX_TURN;
                else if (stp)      state_nx = S_IDLE;
                else if (tx_ready) begin
                    unique case (cmd_q[7:6])
                        PFX_TX:  state_nx = S_TXD;
                        PFX_WR:  state_nx = S_WR;
                        PFX_RD:  state_nx = S_RD_TURN;
                        default: state_nx = S_IDLE;
                    endcase
                end
            end
            S_TXD, S_WR_STP: begin
                if (rx_active) state_nx = S_RX_TURN;
                else if (stp)  state_nx = S_IDLE;
            end
            S_WR: begin
                if (rx_active) state_nx = S_RX_TURN;
                else if (stp)  state_nx = S_IDLE;
                else           state_nx = S_WR_STP;
            end
            S_RD_TURN:  state_nx = S_RD_DATA;
            S_RD_DATA:  state_nx = S_BACK;
            S_RX_TURN:  state_nx = S_RX;
            S_RX:       if (!rx_active) state_nx = S_BACK;
            S_CMD_TURN: state_nx = S_CMD;
            S_CMD:      state_nx = S_BACK;
            S_LP_TURN:  state_nx = S_LP;
            S_LP:       if (!lp_en) state_nx = S_BACK;
            S_BACK:     state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cmd_q   <= '0;
            ls_last <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && state_nx == S_TXC) cmd_q <= bus_in;
            if (state == S_CMD || (state == S_RX && !rx_valid)) ls_last <= line_state;
        end
    end

    always_comb begin
        dir      = 1'b0;
        nxt      = 1'b0;
        bus_oe   = 1'b0;
        bus_out  = '0;
        clk_run  = 1'b1;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_drop  = 1'b0;
        wr_en    = 1'b0;
        unique case (state)
            S_IDLE, S_BACK: ;
            S_TXC: begin
                nxt     = tx_ready;
                tx_drop = rx_active;
            end
            S_TXD: begin
                nxt      = tx_ready;
                tx_drop  = rx_active;
                tx_valid = tx_ready && !stp && !rx_active;
                tx_last  = stp && !rx_active;
            end
            S_WR: begin
                nxt     = 1'b1;
                tx_drop = rx_active;
                wr_en   = !stp && !rx_active;
            end
            S_WR_STP: tx_drop = rx_active;
            S_RD_TURN, S_CMD_TURN, S_LP_TURN: dir = 1'b1;
            S_RD_DATA: begin
                dir     = 1'b1;
                bus_oe  = 1'b1;
                bus_out = rd_data;
            end
            S_RX_TURN: begin
                dir = 1'b1;
                nxt = 1'b1;
            end
            S_RX: begin
                dir    = 1'b1;
                bus_oe = 1'b1;
                if (rx_valid) begin
                    nxt     = 1'b1;
                    bus_out = rx_byte;
                end else begin
                    bus_out = status_byte(rx_active, line_state);
                end
            end
            S_CMD: begin
                dir     = 1'b1;
                bus_oe  = 1'b1;
                bus_out = status_byte(rx_active, line_state);
            end
            S_LP: begin
                dir     = 1'b1;
                bus_oe  = 1'b1;
                clk_run = 1'b0;
                bus_out = sleep_byte(lp_int, line_state);
            end
        endcase
    end
endmodule

// File: rtl/ulpi_phy_port.sv
module ulpi_phy_port #(
    parameter int NREG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       dir,
    output logic       nxt,
    input  logic       stp,
    input  logic       tx_ready,
    output logic [3:0] tx_pid,
    output logic [7:0] tx_byte,
    output logic       tx_valid,
    output logic       tx_last,
    output logic       tx_drop,
    input  logic       rx_active,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic [1:0] line_state,
    input  logic       lp_en,
    input  logic       lp_int,
    output logic       clk_run
);
    localparam int AW = 6;

    logic [7:0] cmd_q;
    logic [7:0] rd_data;
    logic       wr_en;

    ulpi_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .stp(stp),
        .tx_ready(tx_ready), .rx_active(rx_active), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .line_state(line_state), .lp_en(lp_en),
        .lp_int(lp_int), .rd_data(rd_data), .cmd_q(cmd_q),
        .bus_out(bus_out), .bus_oe(bus_oe), .dir(dir), .nxt(nxt),
        .clk_run(clk_run), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_drop(tx_drop), .wr_en(wr_en)
    );

    ulpi_regfile #(.NREG(NREG), .AW(AW), .DW(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(cmd_q[AW-1:0]), .wr_data(bus_in), .rd_data(rd_data)
    );

    assign tx_pid  = cmd_q[3:0];
    assign tx_byte = bus_in;
endmodule

// File: rtl/ulpi_phy_port_chk.sv
module ulpi_phy_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dir,
    input logic       nxt,
    input logic       bus_oe,
    input logic       stp,
    input logic       rx_active,
    input logic       rx_valid,
    input logic       lp_en,
    input logic       clk_run,
    input logic       tx_drop
);
    p_turn_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dir != $past(dir)) |-> !bus_oe);

    p_rx_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir && !$past(dir) && rx_active && !lp_en) |=> (dir && nxt));

    p_stp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nxt) && !$past(dir) && $past(stp) && !$past(rx_active)) |-> (!nxt && !dir));

    p_nxt_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && bus_oe && nxt) |-> rx_valid);

    p_lp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |-> (dir && bus_oe));

    p_drop_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drop |=> (dir && nxt));
endmodule

bind ulpi_phy_port ulpi_phy_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dir(dir), .nxt(nxt), .bus_oe(bus_oe),
    .stp(stp), .rx_active(rx_active), .rx_valid(rx_valid),
    .lp_en(lp_en), .clk_run(clk_run), .tx_drop(tx_drop)
);

// File: tb/sim_ulpi_phy_port.sv
`timescale 1ns/1ps
module sim_ulpi_phy_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe, dir, nxt;
    logic       stp = 1'b0;
    logic       tx_ready = 1'b1;
    logic [3:0] tx_pid;
    logic [7:0] tx_byte;
    logic       tx_valid, tx_last, tx_drop;
    logic       rx_active = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [1:0] line_state = '0;
    logic       lp_en = 1'b0;
    logic       lp_int = 1'b0;
    logic       clk_run;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ulpi_phy_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .dir(dir), .nxt(nxt), .stp(stp),
        .tx_ready(tx_ready), .tx_pid(tx_pid), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_drop(tx_drop),
        .rx_active(rx_active), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .line_state(line_state), .lp_en(lp_en), .lp_int(lp_int),
        .clk_run(clk_run)
    );

    task automatic tick();
        @(posedge clk);
        #0.5;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        #1;
        chk("R1 dir", dir, 0);
        chk("R1 nxt", nxt, 0);
        chk("R1 oe", bus_oe, 0);
        chk("R1 clk_run", clk_run, 1);
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_transmit();
        bus_in = 8'h45; tx_ready = 1'b1; #1;
        chk("R2 first cmd cycle nxt", nxt, 0);
        tick(); #1;
        chk("R2 nxt after first cycle", nxt, 1);
        chk("R3 pid", tx_pid, 4'h5);
        tick(); bus_in = 8'hAA; #1;
        chk("R3 valid", tx_valid, 1);
        chk("R3 byte", tx_byte, 8'hAA);
        tick(); bus_in = 8'hBB; tx_ready = 1'b0; #1;
        chk("R3 throttle nxt", nxt, 0);
        chk("R3 throttle valid", tx_valid, 0);
        tx_ready = 1'b1; #1;
        chk("R3 resume byte", {tx_valid, tx_byte}, {1'b1, 8'hBB});
        tick(); bus_in = 8'h00; stp = 1'b1; #1;
        chk("R4 last", tx_last, 1);
        chk("R4 no byte on stop", tx_valid, 0);
        tick(); stp = 1'b0; #1;
        chk("R4 idle nxt", {dir, nxt}, 0);
        tick(); #1;
        chk("R4 stays idle", {dir, nxt}, 0);
    endtask

    task automatic t_ignore();
        bus_in = 8'h45; stp = 1'b1;
        tick(); tick(); #1;
        chk("R2 stp high ignored", nxt, 0);
        stp = 1'b0; bus_in = 8'h05;
        tick(); tick(); #1;
        chk("R2 prefix 00 ignored", nxt, 0);
        bus_in = 8'h00;
        tick();
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
        bus_in = {2'b10, a};
        tick(); tick();
        bus_in = d; #1;
        chk("R5 write nxt", nxt, 1);
        tick(); bus_in = 8'h00; stp = 1'b1;
        tick(); stp = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, input logic [7:0] exp);
        bus_in = {2'b11, a};
        tick(); tick(); bus_in = 8'h00; #1;
        chk("R6 read turnaround", {dir, bus_oe, nxt}, 3'b100);
        tick(); #1;
        chk("R6 read drive", {dir, bus_oe, nxt}, 3'b110);
        chk("R6 read value", bus_out, exp);
        tick(); #1;
        chk("R12 read return turnaround", {dir, bus_oe}, 0);
        tick();
    endtask

    task automatic t_registers();
        reg_write(6'd3, 8'h5C);
        reg_read(6'd3, 8'h5C);
        reg_write(6'd1, 8'h21);
        reg_write(6'd9, 8'hEE);
        reg_read(6'd1, 8'h21);
        reg_read(6'd63, 8'h00);
    endtask

    task automatic t_receive();
        rx_active = 1'b1; bus_in = 8'h45; #1;
        chk("R13 rx over cmd same cycle", dir, 0);
        tick(); bus_in = 8'h00; #1;
        chk("R7 dir nxt together", {dir, nxt, bus_oe}, 3'b110);
        rx_valid = 1'b1; rx_byte = 8'h3C;
        tick(); #1;
        chk("R8 rx byte", {bus_oe, nxt, bus_out}, {2'b11, 8'h3C});
        rx_valid = 1'b0; #1;
        chk("R8 rx cmd active", {nxt, bus_out}, {1'b0, 8'h10});
        tick(); rx_active = 1'b0; #1;
        chk("R8 rx cmd ended", bus_out, 8'h00);
        tick(); bus_in = 8'h45; #1;
        chk("R8 dir drops", {dir, bus_oe}, 0);
        tick(); bus_in = 8'h00; #1;
        tick(); #1;
        chk("R12 turnaround byte ignored", {dir, nxt}, 0);
    endtask

    task automatic t_abort();
        bus_in = 8'h43;
        tick(); tick(); bus_in = 8'h11; #1;
        chk("R10 byte before abort", tx_valid, 1);
        tick(); bus_in = 8'h22; rx_active = 1'b1; #1;
        chk("R10 drop pulse", {tx_drop, tx_valid, tx_last}, 3'b100);
        tick(); bus_in = 8'h00; #1;
        chk("R10 receive starts", {dir, nxt, tx_last}, 3'b110);
        rx_active = 1'b0;
        tick(); tick(); tick(); #1;
        chk("R10 back idle", {dir, nxt}, 0);
    endtask

    task automatic t_linestate();
        line_state = 2'b01; #1;
        chk("R9 same cycle", dir, 0);
        tick(); #1;
        chk("R9 turnaround", {dir, bus_oe, nxt}, 3'b100);
        tick(); #1;
        chk("R9 rx cmd", {bus_oe, nxt, bus_out}, {2'b10, 8'h01});
        tick(); #1;
        chk("R9 return", {dir, bus_oe}, 0);
        tick(); tick(); #1;
        chk("R9 no repeat", dir, 0);
    endtask

    task automatic t_lowpower();
        lp_en = 1'b1; rx_active = 1'b1; lp_int = 1'b1;
        tick(); #1;
        chk("R13 low power wins", {dir, nxt, bus_oe}, 3'b100);
        rx_active = 1'b0;
        tick(); #1;
        chk("R11 clock stopped", clk_run, 0);
        chk("R11 pins", {bus_oe, bus_out}, {1'b1, 8'h09});
        lp_int = 1'b0; #1;
        chk("R11 interrupt cleared", bus_out, 8'h01);
        tick(); tick(); #1;
        chk("R11 held", {dir, clk_run}, 2'b10);
        lp_en = 1'b0;
        tick(); #1;
        chk("R11 release", {dir, bus_oe, clk_run}, 3'b001);
        tick(); #1;
        chk("R11 idle", {dir, nxt}, 0);
    endtask

    initial begin
        t_reset();
        t_transmit();
        t_ignore();
        t_registers();
        t_receive();
        t_abort();
        t_linestate();
        t_lowpower();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule